// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer whose producer and consumer run on separate, free-running clocks. The clocks may be unrelated or may be the same clock. Each pointer crosses into the other clock domain as a Gray code through a two-stage synchronizer. A flag therefore asserts in the same cycle as an access on its own side. It clears only after the other side's pointer has crossed, which keeps every flag conservative.

Each side has an active-low select and an active-high enable. A transfer takes place on a rising edge only when the select is low and the enable is high. The write side reports a full flag and an active-low almost-full flag. The read side reports a status flag and an active-low almost-empty flag. The read side also drives an output-enable that models the read bus being released whenever the read select is inactive.

Both threshold offsets and the timing mode are captured while reset is held. The standard timing mode presents a word one cycle after a read request, and its status flag means "memory not empty". The fall-through mode presents the oldest word before any read, and its status flag means "a valid word is on the output now".

Top module: `xclk_flag_fifo`

## Requirements
- R1: While reset is held and after it is released, with no transfers, wr_full=0, wr_afull_n=1, rd_avail=0, rd_aempty_n=0 and rd_data=0.
- R2: A write happens only on a wr_clk rising edge with wr_cs_n=0 and wr_en=1. A read request exists only on an rd_clk rising edge with rd_cs_n=0 and rd_en=1. Any other combination stores or removes nothing.
- R3: Words leave on rd_data in exactly the order they were accepted, with no loss and no duplication.
- R4: wr_full is 1 when the write side sees DEPTH words in memory. A write attempted while wr_full=1 is ignored: it leaves the stored data unchanged and does not move the write pointer.
- R5: A read request while the memory holds no word visible to the read side is ignored: rd_data keeps its value and the read pointer does not move.
- R6: rd_aempty_n is 0 exactly when the word count seen by the read side is less than or equal to the almost-empty offset X. In fall-through mode this count includes the word held on the output.
- R7: wr_afull_n is 0 exactly when the number of free memory locations seen by the write side is less than or equal to the almost-full offset Y.
- R8: X (ae_offset), Y (af_offset) and the mode (fwft_sel) are captured only while reset is low. Changing these inputs after reset has no effect.
- R9: In standard mode (fwft_sel=0 during reset), rd_avail=1 means the memory is not empty, and a read request loads rd_data at that edge.
- R10: In fall-through mode (fwft_sel=1 during reset), the oldest word appears on rd_data without a request and rd_avail=1 marks it valid. A request while rd_avail=1 consumes that word. The output word stays unchanged until it is consumed.
- R11: rd_oe equals the inverse of rd_cs_n in every cycle.
- R12: With identical clocks, a word written at edge k makes rd_avail rise after edge k+2 in standard mode and after edge k+3 in fall-through mode. The pointer code crossing domains changes in at most one bit per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side synchronous reset, active low |
| wr_cs_n | input | 1 | Write select, active low |
| wr_en | input | 1 | Write enable |
| wr_data | input | DW | Write data |
| af_offset | input | CW | Almost-full offset Y, captured in reset |
| wr_full | output | 1 | Memory full as seen by the write side |
| wr_afull_n | output | 1 | Almost-full flag, active low |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side synchronous reset, active low |
| rd_cs_n | input | 1 | Read select, active low |
| rd_en | input | 1 | Read enable |
| ae_offset | input | CW | Almost-empty offset X, captured in reset |
| fwft_sel | input | 1 | Mode select captured in reset: 0 standard, 1 fall-through |
| rd_data | output | DW | Read data |
| rd_oe | output | 1 | Read bus drive enable |
| rd_avail | output | 1 | Standard: memory not empty; fall-through: output word valid |
| rd_aempty_n | output | 1 | Almost-empty flag, active low |

## Verification
The in-line assertions check the following on every cycle:
- the write pointer holds on a write attempted while full, and a read request against an empty memory leaves the read pointer in place;
- the occupied count never exceeds the depth;
- each crossing pointer code moves by at most one bit;
- the captured offsets and mode hold outside reset;
- in fall-through mode, the output word and its valid flag are held until a request consumes them.

The word order, the exact thresholds of both almost flags, and the two- and three-edge crossing latency can only be shown by the bench's scenarios, run against its cycle model. The same holds for the effect of an inactive select on each side.

// File: rtl/afifo_pkg.sv
// Shared types for the dual-clock flag FIFO.
package afifo_pkg;
    // Output timing mode captured while the read side is in reset.
    typedef enum logic {
        TM_STANDARD = 1'b0,
        TM_FALLTHRU = 1'b1
    } tmode_e;
endpackage

// File: rtl/afifo_sync.sv
// Brings a Gray-coded pointer into the destination clock domain through two
// flops and converts it to binary there.
// Assumes the source changes the Gray code in at most one bit per edge.
module afifo_sync #(
    parameter int PW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] bin_out
);
    logic [PW-1:0] meta_q;
    logic [PW-1:0] stable_q;

    // Two-stage capture of the foreign pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= gray_in;
            stable_q <= meta_q;
        end
    end

    // Gray to binary: each bit is the parity of itself and all higher bits.
    for (genvar i = 0; i < PW; i++) begin : g_g2b
        assign bin_out[i] = ^stable_q[PW-1:i];
    end
endmodule

// File: rtl/afifo_mem.sv
// Storage array: one clocked write port in the write domain and one
// combinational read port used by the read domain.
// Assumes the control logic never writes the slot that is being read.
module afifo_mem #(
    parameter int DW = 18,
    parameter int AW = 6
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int SLOTS = 1 << AW;

    logic [DW-1:0] store [SLOTS];

    // Write one word per accepted write.
    always_ff @(posedge wclk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/afifo_wr_side.sv
// Write-domain control: write pointer, its Gray copy for the crossing, the
// full flag and the almost-full flag against offset Y.
// Assumes rd_ptr_sync is the read pointer already brought into this domain.
module afifo_wr_side #(
    parameter int DEPTH = 64,
    parameter int AW    = 6,
    parameter int PW    = 7,
    parameter int CW    = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          en,
    input  logic [CW-1:0] af_offset,
    input  logic [PW-1:0] rd_ptr_sync,
    output logic [PW-1:0] wr_gray,
    output logic [AW-1:0] waddr,
    output logic          wr_go,
    output logic          full,
    output logic          afull_n
);
    logic [PW-1:0] wptr_q;
    logic [PW-1:0] wgray_q;
    logic [PW-1:0] wptr_nxt;
    logic [PW-1:0] used;
    logic [CW-1:0] free_cnt;
    logic [CW-1:0] y_q;

    assign used     = wptr_q - rd_ptr_sync;
    assign full     = (used == PW'(DEPTH));
    assign free_cnt = CW'(DEPTH) - CW'(used);
    assign afull_n  = !(free_cnt <= y_q);
    assign wr_go    = rst_n && !cs_n && en && !full;
    assign wptr_nxt = wptr_q + PW'(1);
    assign wr_gray  = wgray_q;
    assign waddr    = wptr_q[AW-1:0];

    // Advance the pointer on an accepted write; capture Y during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q  <= '0;
            wgray_q <= '0;
            y_q     <= af_offset;
        end else if (wr_go) begin
            wptr_q  <= wptr_nxt;
            wgray_q <= wptr_nxt ^ (wptr_nxt >> 1);
        end
    end

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !cs_n && en) |=> (wptr_q == $past(wptr_q)));
    // R4
    used_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        used <= PW'(DEPTH));
    // R12
    wgray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($countones(wgray_q ^ $past(wgray_q)) <= 1));
    // R8
    yoff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(y_q));
endmodule

// File: rtl/afifo_rd_side.sv
// Read-domain control: read pointer, output register, mode-dependent status
// flag, and the almost-empty flag against offset X.
// Assumes wr_ptr_sync is the write pointer already brought into this domain,
// and that fwft_sel is steady while reset is held.
module afifo_rd_side
    import afifo_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 18,
    parameter int AW    = 6,
    parameter int PW    = 7,
    parameter int CW    = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          en,
    input  logic [CW-1:0] ae_offset,
    input  logic          fwft_sel,
    input  logic [PW-1:0] wr_ptr_sync,
    input  logic [DW-1:0] mem_rdata,
    output logic [PW-1:0] rd_gray,
    output logic [AW-1:0] raddr,
    output logic [DW-1:0] rd_data,
    output logic          oe,
    output logic          avail,
    output logic          aempty_n
);
    logic [PW-1:0] rptr_q;
    logic [PW-1:0] rgray_q;
    logic [PW-1:0] rptr_nxt;
    logic [PW-1:0] mcount;
    logic [DW-1:0] dout_q;
    logic [CW-1:0] x_q;
    logic [CW-1:0] total;
    tmode_e        mode_q;
    logic          ov_q;
    logic          mem_empty;
    logic          req;
    logic          take;
    logic          fetch;

    assign mcount    = wr_ptr_sync - rptr_q;
    assign mem_empty = (mcount == '0);
    assign req       = rst_n && !cs_n && en;
    assign rptr_nxt  = rptr_q + PW'(1);

    // Decide fetch/consume and the status flag for the captured mode.
    always_comb begin
        unique case (mode_q)
            TM_FALLTHRU: begin
                take  = req && ov_q;
                fetch = rst_n && !mem_empty && (!ov_q || take);
                avail = ov_q;
                total = CW'(mcount) + CW'(ov_q);
            end
            default: begin
                take  = 1'b0;
                fetch = req && !mem_empty;
                avail = !mem_empty;
                total = CW'(mcount);
            end
        endcase
    end

    // Move words out of memory; capture X and the mode during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr_q  <= '0;
            rgray_q <= '0;
            dout_q  <= '0;
            ov_q    <= 1'b0;
            x_q     <= ae_offset;
            mode_q  <= tmode_e'(fwft_sel);
        end else begin
            if (fetch) begin
                rptr_q  <= rptr_nxt;
                rgray_q <= rptr_nxt ^ (rptr_nxt >> 1);
                dout_q  <= mem_rdata;
            end
            if (fetch && mode_q == TM_FALLTHRU) begin
                ov_q <= 1'b1;
            end else if (take) begin
                ov_q <= 1'b0;
            end
        end
    end

    assign aempty_n = !(total <= x_q);
    assign oe       = !cs_n;
    assign rd_data  = dout_q;
    assign rd_gray  = rgray_q;
    assign raddr    = rptr_q[AW-1:0];

    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_empty && !cs_n && en) |=> (rptr_q == $past(rptr_q)));
    // R10
    ov_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ov_q) && $past(rst_n)) |-> $past(!cs_n && en));
    // R10
    ov_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_q && (cs_n || !en)) |=> ($stable(dout_q) && ov_q));
    // R8
    rd_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(x_q) && $stable(mode_q)));
    // R12
    rgray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($countones(rgray_q ^ $past(rgray_q)) <= 1));
    // R6
    total_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        total <= CW'(DEPTH + 1));
endmodule

// File: rtl/xclk_flag_fifo.sv
// Dual-clock FIFO with programmable almost-empty / almost-full flags and a
// reset-selected standard or fall-through output timing.
// Assumes DEPTH is a power of two and each reset is held at least two cycles
// of its own clock with offsets and mode steady.
module xclk_flag_fifo #(
    parameter int DEPTH = 64,
    parameter int DW    = 18,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1,
    localparam int CW   = $clog2(DEPTH + 2)
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          wr_cs_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic [CW-1:0] af_offset,
    output logic          wr_full,
    output logic          wr_afull_n,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          rd_cs_n,
    input  logic          rd_en,
    input  logic [CW-1:0] ae_offset,
    input  logic          fwft_sel,
    output logic [DW-1:0] rd_data,
    output logic          rd_oe,
    output logic          rd_avail,
    output logic          rd_aempty_n
);
    logic [PW-1:0] wr_gray;
    logic [PW-1:0] rd_gray;
    logic [PW-1:0] wr_ptr_in_rd;
    logic [PW-1:0] rd_ptr_in_wr;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [DW-1:0] mem_rdata;
    logic          wr_go;

    afifo_wr_side #(.DEPTH(DEPTH), .AW(AW), .PW(PW), .CW(CW)) u_wr (
        .clk(wr_clk), .rst_n(wr_rst_n), .cs_n(wr_cs_n), .en(wr_en),
        .af_offset(af_offset), .rd_ptr_sync(rd_ptr_in_wr),
        .wr_gray(wr_gray), .waddr(waddr), .wr_go(wr_go),
        .full(wr_full), .afull_n(wr_afull_n)
    );

    afifo_sync #(.PW(PW)) u_w2r (
        .clk(rd_clk), .rst_n(rd_rst_n), .gray_in(wr_gray), .bin_out(wr_ptr_in_rd)
    );

    afifo_sync #(.PW(PW)) u_r2w (
        .clk(wr_clk), .rst_n(wr_rst_n), .gray_in(rd_gray), .bin_out(rd_ptr_in_wr)
    );

    afifo_mem #(.DW(DW), .AW(AW)) u_mem (
        .wclk(wr_clk), .we(wr_go), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(mem_rdata)
    );

    afifo_rd_side #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .PW(PW), .CW(CW)) u_rd (
        .clk(rd_clk), .rst_n(rd_rst_n), .cs_n(rd_cs_n), .en(rd_en),
        .ae_offset(ae_offset), .fwft_sel(fwft_sel),
        .wr_ptr_sync(wr_ptr_in_rd), .mem_rdata(mem_rdata),
        .rd_gray(rd_gray), .raddr(raddr), .rd_data(rd_data),
        .oe(rd_oe), .avail(rd_avail), .aempty_n(rd_aempty_n)
    );
endmodule

// File: tb/xclk_flag_fifo_test.sv
module xclk_flag_fifo_test;
    localparam int DEPTH = 64;
    localparam int DW    = 18;
    localparam int CW    = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_cs_n = 1'b1, wr_en = 1'b0, rd_cs_n = 1'b1, rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [CW-1:0] af_off = 7'd8, ae_off = 7'd8;
    logic          fwft_sel = 1'b0;
    logic          wr_full, wr_afull_n, rd_oe, rd_avail, rd_aempty_n;
    logic [DW-1:0] rd_data;

    int errors = 0;
    int checks = 0;
    bit started = 0;
    bit done = 0;

    always #10 clk = ~clk;

    xclk_flag_fifo uut (
        .wr_clk(clk), .wr_rst_n(rst_n), .wr_cs_n(wr_cs_n), .wr_en(wr_en),
        .wr_data(wr_data), .af_offset(af_off), .wr_full(wr_full),
        .wr_afull_n(wr_afull_n),
        .rd_clk(clk), .rd_rst_n(rst_n), .rd_cs_n(rd_cs_n), .rd_en(rd_en),
        .ae_offset(ae_off), .fwft_sel(fwft_sel), .rd_data(rd_data),
        .rd_oe(rd_oe), .rd_avail(rd_avail), .rd_aempty_n(rd_aempty_n)
    );

    // Behavioural reference: counts, a data queue and plain delays for the crossings.
    logic [DW-1:0] q[$];
    int  wcnt, rcnt, ws1, ws2, rs1, rs2, mx, my;
    bit  mmode, mov;
    logic [DW-1:0] mdout;

    always @(posedge clk) begin
        int wpre, rpre;
        bit rq, take, fetch;
        started = 1;
        if (!rst_n) begin
            wcnt = 0; rcnt = 0; ws1 = 0; ws2 = 0; rs1 = 0; rs2 = 0;
            mx = int'(ae_off); my = int'(af_off); mmode = fwft_sel;
            mov = 0; mdout = '0; q.delete();
        end else begin
            wpre = wcnt; rpre = rcnt;
            rq = !rd_cs_n && rd_en;
            if (!mmode) begin
                if (rq && (ws2 - rcnt) != 0) begin mdout = q.pop_front(); rcnt++; end
            end else begin
                take  = rq && mov;
                fetch = (ws2 - rcnt) != 0 && (!mov || take);
                if (fetch) begin mdout = q.pop_front(); rcnt++; mov = 1; end
                else if (take) mov = 0;
            end
            if (!wr_cs_n && wr_en && (wcnt - rs2) != DEPTH) begin
                q.push_back(wr_data); wcnt++;
            end
            ws2 = ws1; ws1 = wpre; rs2 = rs1; rs1 = rpre;
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Compare every output with the reference on every falling edge.
    always @(negedge clk) begin
        int tot;
        if (started && !done) begin
            tot = (ws2 - rcnt) + (mmode ? int'(mov) : 0);
            chk("R4", "wr_full", 32'(wr_full), 32'((wcnt - rs2) == DEPTH));
            chk("R7", "wr_afull_n", 32'(wr_afull_n), 32'(!((DEPTH - (wcnt - rs2)) <= my)));
            chk(mmode ? "R10" : "R9", "rd_avail", 32'(rd_avail),
                32'(mmode ? mov : ((ws2 - rcnt) != 0)));
            chk("R6", "rd_aempty_n", 32'(rd_aempty_n), 32'(!(tot <= mx)));
            chk("R3", "rd_data", 32'(rd_data), 32'(mdout));
            chk("R11", "rd_oe", 32'(rd_oe), 32'(!rd_cs_n));
        end
    end

    task automatic step(input bit wcs, input bit wen, input logic [DW-1:0] wd,
                        input bit rcs, input bit ren);
        wr_cs_n = wcs; wr_en = wen; wr_data = wd; rd_cs_n = rcs; rd_en = ren;
        @(posedge clk); #2;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1, 0, '0, 1, 0);
    endtask

    task automatic traffic(input int n, input int wbias, input int rbias);
        logic [15:0] lf = 16'hACE1;
        for (int i = 0; i < n; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[7] & lf[9], int'(lf[3:0]) < wbias, {lf[1:0], lf},
                 lf[11] & lf[6], int'(lf[15:12]) < rbias);
        end
    endtask

    task automatic do_reset(input bit mode, input int x, input int y);
        rst_n = 0; fwft_sel = mode; ae_off = CW'(x); af_off = CW'(y);
        idle(3);
        rst_n = 1;
    endtask

    initial begin
        do_reset(0, 8, 8);
        // R1: reset state observed while reset is held
        chk("R1", "full in reset", 32'(wr_full), 0);
        chk("R1", "afull_n in reset", 32'(wr_afull_n), 1);
        chk("R1", "avail in reset", 32'(rd_avail), 0);
        chk("R1", "aempty_n in reset", 32'(rd_aempty_n), 0);
        chk("R1", "rd_data in reset", 32'(rd_data), 0);
        ae_off = 7'd50; af_off = 7'd2;  // R8: no effect after reset
        idle(1);
        chk("R1", "avail after release", 32'(rd_avail), 0);

        // R2: writes without both qualifiers store nothing
        for (int i = 0; i < 3; i++) step(1, 1, 18'h111, 1, 0);
        for (int i = 0; i < 3; i++) step(0, 0, 18'h222, 1, 0);
        idle(4);
        chk("R2", "avail after unqualified writes", 32'(rd_avail), 0);

        // R12: crossing latency, standard mode
        step(0, 1, 18'h123, 1, 0);
        chk("R12", "avail after k", 32'(rd_avail), 0);
        step(1, 0, '0, 1, 0);
        chk("R12", "avail after k+1", 32'(rd_avail), 0);
        step(1, 0, '0, 1, 0);
        chk("R12", "avail after k+2", 32'(rd_avail), 1);

        // R9 / R5: read the word, then read while empty
        step(1, 0, '0, 0, 1);
        chk("R9", "data after read", 32'(rd_data), 32'h123);
        for (int i = 0; i < 3; i++) step(1, 0, '0, 0, 1);
        chk("R5", "data kept on empty read", 32'(rd_data), 32'h123);

        // R4: overfill, then drain
        for (int i = 0; i < 70; i++) step(0, 1, 18'(i + 16'h400), 1, 0);
        chk("R4", "full after overfill", 32'(wr_full), 1);
        chk("R8", "aempty_n ignores new X", 32'(rd_aempty_n), 1);
        chk("R7", "afull_n at full", 32'(wr_afull_n), 0);
        for (int i = 0; i < 70; i++) step(1, 0, '0, 0, 1);
        chk("R4", "last word kept", 32'(rd_data), 32'h43F);
        idle(3);

        traffic(250, 14, 6);
        traffic(250, 5, 14);
        rd_cs_n = 1; #1;
        chk("R11", "oe with cs high", 32'(rd_oe), 0);
        rd_cs_n = 0; #1;
        chk("R11", "oe with cs low", 32'(rd_oe), 1);
        idle(3);

        // Fall-through mode
        do_reset(1, 3, 5);
        step(0, 1, 18'h2AA, 1, 0);
        chk("R10", "valid after k", 32'(rd_avail), 0);
        idle(2);
        chk("R10", "valid after k+2", 32'(rd_avail), 0);
        idle(1);
        chk("R12", "valid after k+3", 32'(rd_avail), 1);
        chk("R10", "word shown without read", 32'(rd_data), 32'h2AA);
        step(1, 0, '0, 0, 1);
        chk("R10", "valid cleared by read", 32'(rd_avail), 0);
        for (int i = 0; i < 70; i++) step(0, 1, 18'(i + 16'h800), 1, 0);
        idle(4);
        chk("R4", "full in fall-through", 32'(wr_full), 1);
        for (int i = 0; i < 70; i++) step(1, 0, '0, 0, 1);
        traffic(250, 14, 6);
        traffic(250, 5, 14);
        idle(4);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule